// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and shares it among several requesters. Each requester offers one operation through a valid/ready handshake. An operation is a plain read, a plain write, test-and-set, exchange, compare-and-swap or fetch-and-increment. A round-robin arbiter picks one requester at a time. The unit then reads the addressed word and writes the result back under that single grant. No other requester reaches the memory between the read and the write, so every operation is indivisible.

For every operation the unit returns one response. It carries the word's value from before the operation, a success flag, and the index of the requester it belongs to. The response is a single-cycle pulse. Software-style locks map onto it directly. A requester acquires a lock when test-and-set returns zero. It releases the lock with a plain write of zero. Counters and lock-free updates use fetch-and-increment and compare-and-swap.

Top module: `amu_top`

## Requirements
- R1: While `rst` is high no request is accepted (`req_ready` is all zero) and `resp_valid` is low.
- R2: A request is accepted at a rising edge where its `req_valid` and `req_ready` are both high. The response is on the outputs for exactly one cycle, starting three rising edges after the accepting edge, and `resp_id` equals the accepted requester's index.
- R3: At most one `req_ready` bit is high, and only for a requester with `req_valid` high. After an acceptance, no further request is accepted at the next two rising edges. With a backlog, successive acceptances are exactly three cycles apart.
- R4: Grants rotate. After requester k was served, the next grant goes to the first valid requester found by searching upward from k+1 and wrapping. After reset the search starts at requester 0.
- R5: Opcode 0 (read) returns the word and leaves memory unchanged; `resp_ok` is 1.
- R6: Opcode 1 (write) stores the operand and returns the previous word; `resp_ok` is 1.
- R7: Opcode 2 (test-and-set) returns the previous word and always stores 1; `resp_ok` is 1 only when the previous word was 0.
- R8: Opcode 3 (exchange) stores the operand and returns the previous word; `resp_ok` is 1.
- R9: Opcode 4 (compare-and-swap) stores the operand only when the word equals the compare input. `resp_ok` is 1 when they matched and 0 otherwise, and the previous word is returned either way.
- R10: Opcode 5 (fetch-and-increment) returns the previous word and stores it plus one, modulo 2^DATA_W.
- R11: Opcodes 6 and 7 leave memory unchanged, return the word and give `resp_ok` 0.
- R12: When several requesters run the same operation on one word at the same time, the result equals some serial order of those operations. Concurrent increments return distinct consecutive values, and exactly one of several concurrent test-and-sets on a free lock succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Request taken at this edge, one-hot or zero |
| req_op | input | NUM_REQ*3 | Opcode per requester, requester i at bits [3i+2:3i] |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester |
| req_wdata | input | NUM_REQ*DATA_W | Operand (value to store) per requester |
| req_cmp | input | NUM_REQ*DATA_W | Compare value per requester (compare-and-swap only) |
| resp_valid | output | 1 | Response pulse, one cycle |
| resp_id | output | ID_W | Index of the requester being answered |
| resp_old | output | DATA_W | Word value before the operation |
| resp_ok | output | 1 | Success flag |

## Verification
Each opcode runs alone first, on words whose prior contents the bench set. Each run checks both cases of its success flag, for example compare-and-swap with a matching and a mismatching compare value, and test-and-set on a free and a held lock. Increment at the all-ones value checks the wrap. The reserved opcodes show that memory is left untouched. All requesters then fire at once, first with increments and then with test-and-sets on one word. Distinct consecutive returned values and a single lock winner tell a correct indivisible read-write apart from an interleaved one. A partial mask of requesters tells true rotation apart from fixed priority. The spacing of grants under that backlog shows that no access enters between a read and its write.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_TAS   = 3'd2,
    OP_XCHG  = 3'd3,
    OP_CAS   = 3'd4,
    OP_FINC  = 3'd5
  } amu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } amu_state_e;

endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic            advance,
  output logic [N-1:0]    grant_oh,
  output logic [ID_W-1:0] grant_id,
  output logic            any_req
);

  logic [ID_W-1:0] last_q;

  // search upward from the requester after the last one served
  always_comb begin
    logic found;
    int   idx;
    found    = 1'b0;
    grant_oh = '0;
    grant_id = '0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        found         = 1'b1;
        grant_oh[idx] = 1'b1;
        grant_id      = ID_W'(idx);
      end
    end
    any_req = found;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= ID_W'(N - 1);
    end else if (advance) begin
      last_q <= grant_id;
    end
  end

endmodule

// File: rtl/amu_mem.sv
module amu_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
    rdata <= store_q[raddr];
  end

endmodule

// File: rtl/amu_alu.sv
module amu_alu
  import amu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amu_op_e           op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              wr_en,
  output logic              ok
);

  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    ok      = 1'b1;
    case (op)
      OP_READ: begin
        wr_en = 1'b0;
      end
      OP_WRITE, OP_XCHG: begin
        new_val = operand;
        wr_en   = 1'b1;
      end
      OP_TAS: begin
        new_val = DATA_W'(1);
        wr_en   = 1'b1;
        ok      = (old_val == '0);
      end
      OP_CAS: begin
        new_val = operand;
        ok      = (old_val == cmp_val);
        wr_en   = ok;
      end
      OP_FINC: begin
        new_val = old_val + DATA_W'(1);
        wr_en   = 1'b1;
      end
      default: begin
        ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/amu_top.sv
module amu_top
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REQ-1:0]        req_valid,
  output logic [NUM_REQ-1:0]        req_ready,
  input  logic [NUM_REQ*OP_W-1:0]   req_op,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
  input  logic [NUM_REQ*DATA_W-1:0] req_cmp,
  output logic                      resp_valid,
  output logic [ID_W-1:0]           resp_id,
  output logic [DATA_W-1:0]         resp_old,
  output logic                      resp_ok
);

  logic [OP_W-1:0]   op_a    [NUM_REQ];
  logic [ADDR_W-1:0] addr_a  [NUM_REQ];
  logic [DATA_W-1:0] wdata_a [NUM_REQ];
  logic [DATA_W-1:0] cmp_a   [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_unpack
    assign op_a[g]    = req_op[g*OP_W +: OP_W];
    assign addr_a[g]  = req_addr[g*ADDR_W +: ADDR_W];
    assign wdata_a[g] = req_wdata[g*DATA_W +: DATA_W];
    assign cmp_a[g]   = req_cmp[g*DATA_W +: DATA_W];
  end

  amu_state_e        state_q;
  amu_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] cmp_q;
  logic [ID_W-1:0]   id_q;

  logic [NUM_REQ-1:0] grant_oh;
  logic [ID_W-1:0]    grant_id;
  logic               any_req;
  logic               can_take;
  logic               take;

  assign can_take  = (state_q == ST_IDLE) && !rst;
  assign take      = can_take && any_req;
  assign req_ready = grant_oh & {NUM_REQ{can_take}};

  amu_rr_arb #(
    .N    (NUM_REQ),
    .ID_W (ID_W)
  ) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (req_valid),
    .advance  (take),
    .grant_oh (grant_oh),
    .grant_id (grant_id),
    .any_req  (any_req)
  );

  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] alu_new;
  logic              alu_we;
  logic              alu_ok;
  logic              mem_we;

  assign mem_we = (state_q == ST_WRITE) && alu_we;

  amu_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .raddr (addr_q),
    .rdata (mem_rdata),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (alu_new)
  );

  amu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op      (op_q),
    .old_val (mem_rdata),
    .operand (wdata_q),
    .cmp_val (cmp_q),
    .new_val (alu_new),
    .wr_en   (alu_we),
    .ok      (alu_ok)
  );

  // operation capture
  always_ff @(posedge clk) begin
    if (take) begin
      op_q    <= amu_op_e'(op_a[grant_id]);
      addr_q  <= addr_a[grant_id];
      wdata_q <= wdata_a[grant_id];
      cmp_q   <= cmp_a[grant_id];
      id_q    <= grant_id;
    end
  end

  // sequencer: the grant covers the read cycle and the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (take) state_q <= ST_READ;
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_id    <= '0;
      resp_old   <= '0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= (state_q == ST_WRITE);
      if (state_q == ST_WRITE) begin
        resp_id  <= id_q;
        resp_old <= mem_rdata;
        resp_ok  <= alu_ok;
      end
    end
  end

endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int NUM_REQ = 4,
  parameter int ID_W    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_valid,
  input logic [NUM_REQ-1:0] req_ready,
  input logic               resp_valid,
  input logic [ID_W-1:0]    resp_id
);

  logic            acc;
  logic [ID_W-1:0] acc_id;

  assign acc = |(req_valid & req_ready);

  always_comb begin
    acc_id = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_valid[i] && req_ready[i]) acc_id = ID_W'(i);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !resp_valid);

  assert_ready_while_reset_R1: assert property (@(posedge clk)
    rst |-> (req_ready == '0));

  assert_ready_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  assert_busy_first_R3: assert property (@(posedge clk) disable iff (rst)
    $past(acc) |-> (req_ready == '0));

  assert_busy_second_R3: assert property (@(posedge clk) disable iff (rst)
    $past(acc, 2) |-> (req_ready == '0));

  assert_resp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    $past(acc, 3) |-> (resp_valid && resp_id == $past(acc_id, 3)));

  assert_resp_cause_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(acc, 3));

  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

endmodule

bind amu_top amu_checker #(
  .NUM_REQ (NUM_REQ),
  .ID_W    (ID_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_id    (resp_id)
);

// File: tb/sim_amu_top.sv
module sim_amu_top;

  localparam int N    = 4;
  localparam int AW   = 6;
  localparam int DW   = 32;
  localparam int OW   = 3;
  localparam int IDW  = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    b_valid;
  logic [N-1:0]    req_ready;
  logic [OW-1:0]   b_op    [N];
  logic [AW-1:0]   b_addr  [N];
  logic [DW-1:0]   b_wdata [N];
  logic [DW-1:0]   b_cmp   [N];
  logic [N*OW-1:0] f_op;
  logic [N*AW-1:0] f_addr;
  logic [N*DW-1:0] f_wdata;
  logic [N*DW-1:0] f_cmp;
  logic            resp_valid;
  logic [IDW-1:0]  resp_id;
  logic [DW-1:0]   resp_old;
  logic            resp_ok;

  int n_chk  = 0;
  int n_fail = 0;
  int last_id = N - 1;
  bit done = 1'b0;

  int        g_id  [8];
  logic [DW-1:0] g_old [8];
  logic      g_ok  [8];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      f_op[i*OW +: OW]    = b_op[i];
      f_addr[i*AW +: AW]  = b_addr[i];
      f_wdata[i*DW +: DW] = b_wdata[i];
      f_cmp[i*DW +: DW]   = b_cmp[i];
    end
  end

  amu_top #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (b_valid),
    .req_ready  (req_ready),
    .req_op     (f_op),
    .req_addr   (f_addr),
    .req_wdata  (f_wdata),
    .req_cmp    (f_cmp),
    .resp_valid (resp_valid),
    .resp_id    (resp_id),
    .resp_old   (resp_old),
    .resp_ok    (resp_ok)
  );

  task automatic chk(input bit cond, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request alone; checks latency, id, old value and flag
  task automatic do_op(input int id, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cv,
                       input bit check_old, input logic [DW-1:0] exp_old,
                       input logic exp_ok, input string tag);
    @(negedge clk);
    b_valid[id] = 1'b1;
    b_op[id] = op; b_addr[id] = a; b_wdata[id] = wd; b_cmp[id] = cv;
    #1;
    chk(req_ready[id] == 1'b1, {tag, " R3 ready"}, 64'(req_ready), 64'(1 << id));
    @(negedge clk);
    b_valid[id] = 1'b0;
    chk(resp_valid == 1'b0, {tag, " R2 early"}, 64'(resp_valid), 0);
    @(negedge clk);
    chk(resp_valid == 1'b0, {tag, " R2 early"}, 64'(resp_valid), 0);
    @(negedge clk);
    chk(resp_valid == 1'b1, {tag, " R2 resp"}, 64'(resp_valid), 1);
    chk(int'(resp_id) == id, {tag, " R2 id"}, 64'(resp_id), 64'(id));
    if (check_old) chk(resp_old == exp_old, {tag, " old"}, 64'(resp_old), 64'(exp_old));
    chk(resp_ok == exp_ok, {tag, " ok"}, 64'(resp_ok), 64'(exp_ok));
    last_id = id;
  endtask

  // several requesters at once; records responses in arrival order
  task automatic run_group(input logic [N-1:0] mask, input logic [2:0] op,
                           input logic [AW-1:0] a, input logic [DW-1:0] wd, output int nresp);
    int nexp;
    int cyc;
    int last_acc;
    logic [N-1:0] snap;
    nresp = 0; cyc = 0; last_acc = -1;
    nexp = $countones(mask);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        b_valid[i] = 1'b1; b_op[i] = op; b_addr[i] = a; b_wdata[i] = wd; b_cmp[i] = '0;
      end
    end
    while (nresp < nexp) begin
      #1;
      snap = req_ready & b_valid;
      if (resp_valid) begin
        g_id[nresp] = int'(resp_id); g_old[nresp] = resp_old; g_ok[nresp] = resp_ok;
        nresp++;
      end
      if (snap != '0) begin
        if (last_acc >= 0) chk(cyc - last_acc == 3, "R3 grant spacing", 64'(cyc - last_acc), 3);
        last_acc = cyc;
      end
      @(negedge clk);
      cyc++;
      b_valid = b_valid & ~snap;
    end
  endtask

  task automatic check_rotation(input logic [N-1:0] mask, input int nresp);
    int k = 0;
    int idx;
    for (int j = 1; j <= N; j++) begin
      idx = (last_id + j) % N;
      if (mask[idx]) begin
        chk(k < nresp && g_id[k] == idx, "R4 grant order", 64'(g_id[k]), 64'(idx));
        k++;
      end
    end
    last_id = g_id[nresp-1];
  endtask

  task automatic t_reset();
    rst = 1'b1;
    b_valid = '1;
    for (int i = 0; i < N; i++) begin
      b_op[i] = 3'd0; b_addr[i] = '0; b_wdata[i] = '0; b_cmp[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == '0, "R1 ready in reset", 64'(req_ready), 0);
    chk(resp_valid == 1'b0, "R1 resp in reset", 64'(resp_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    b_valid = '0;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R1 resp after reset", 64'(resp_valid), 0);
  endtask

  task automatic t_read_write();
    do_op(0, 3'd1, 6'd3, 32'hA5A5_0001, '0, 1'b0, '0, 1'b1, "R6 first write");
    do_op(1, 3'd0, 6'd3, '0, '0, 1'b1, 32'hA5A5_0001, 1'b1, "R5 read");
    do_op(2, 3'd0, 6'd3, '0, '0, 1'b1, 32'hA5A5_0001, 1'b1, "R5 read unchanged");
    do_op(3, 3'd1, 6'd3, 32'h0000_BEEF, '0, 1'b1, 32'hA5A5_0001, 1'b1, "R6 write old");
    do_op(0, 3'd0, 6'd3, '0, '0, 1'b1, 32'h0000_BEEF, 1'b1, "R6 stored");
  endtask

  task automatic t_tas();
    do_op(1, 3'd1, 6'd5, 32'd0, '0, 1'b0, '0, 1'b1, "R7 clear lock");
    do_op(2, 3'd2, 6'd5, 32'hDEAD, '0, 1'b1, 32'd0, 1'b1, "R7 acquire");
    do_op(3, 3'd2, 6'd5, 32'hDEAD, '0, 1'b1, 32'd1, 1'b0, "R7 held");
    do_op(0, 3'd1, 6'd5, 32'd0, '0, 1'b1, 32'd1, 1'b1, "R7 release");
    do_op(3, 3'd2, 6'd5, '0, '0, 1'b1, 32'd0, 1'b1, "R7 reacquire");
  endtask

  task automatic t_xchg();
    do_op(0, 3'd1, 6'd7, 32'h1111_2222, '0, 1'b0, '0, 1'b1, "R8 setup");
    do_op(1, 3'd3, 6'd7, 32'h3333_4444, '0, 1'b1, 32'h1111_2222, 1'b1, "R8 exchange");
    do_op(2, 3'd0, 6'd7, '0, '0, 1'b1, 32'h3333_4444, 1'b1, "R8 stored");
  endtask

  task automatic t_cas();
    do_op(3, 3'd1, 6'd8, 32'd50, '0, 1'b0, '0, 1'b1, "R9 setup");
    do_op(0, 3'd4, 6'd8, 32'd77, 32'd49, 1'b1, 32'd50, 1'b0, "R9 miss");
    do_op(1, 3'd0, 6'd8, '0, '0, 1'b1, 32'd50, 1'b1, "R9 miss unchanged");
    do_op(2, 3'd4, 6'd8, 32'd77, 32'd50, 1'b1, 32'd50, 1'b1, "R9 hit");
    do_op(3, 3'd0, 6'd8, '0, '0, 1'b1, 32'd77, 1'b1, "R9 hit stored");
  endtask

  task automatic t_finc();
    do_op(0, 3'd1, 6'd10, 32'hFFFF_FFFE, '0, 1'b0, '0, 1'b1, "R10 setup");
    do_op(1, 3'd5, 6'd10, '0, '0, 1'b1, 32'hFFFF_FFFE, 1'b1, "R10 inc");
    do_op(2, 3'd5, 6'd10, '0, '0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R10 inc at top");
    do_op(3, 3'd0, 6'd10, '0, '0, 1'b1, 32'd0, 1'b1, "R10 wrapped");
  endtask

  task automatic t_reserved();
    do_op(0, 3'd1, 6'd11, 32'h0BAD_F00D, '0, 1'b0, '0, 1'b1, "R11 setup");
    do_op(1, 3'd6, 6'd11, 32'h1234, 32'h0BAD_F00D, 1'b1, 32'h0BAD_F00D, 1'b0, "R11 op6");
    do_op(2, 3'd7, 6'd11, 32'h5678, '0, 1'b1, 32'h0BAD_F00D, 1'b0, "R11 op7");
    do_op(3, 3'd0, 6'd11, '0, '0, 1'b1, 32'h0BAD_F00D, 1'b1, "R11 unchanged");
  endtask

  task automatic t_concurrent_inc();
    int nr;
    do_op(1, 3'd1, 6'd9, 32'd0, '0, 1'b0, '0, 1'b1, "R12 inc setup");
    run_group(4'b1111, 3'd5, 6'd9, '0, nr);
    chk(nr == 4, "R12 inc responses", 64'(nr), 4);
    check_rotation(4'b1111, nr);
    for (int k = 0; k < 4; k++)
      chk(g_old[k] == DW'(k), "R12 inc serial value", 64'(g_old[k]), 64'(k));
    do_op(0, 3'd0, 6'd9, '0, '0, 1'b1, 32'd4, 1'b1, "R12 inc total");
    run_group(4'b1010, 3'd5, 6'd9, '0, nr);
    check_rotation(4'b1010, nr);
    run_group(4'b0111, 3'd5, 6'd9, '0, nr);
    check_rotation(4'b0111, nr);
    do_op(2, 3'd0, 6'd9, '0, '0, 1'b1, 32'd9, 1'b1, "R12 inc total 2");
  endtask

  task automatic t_concurrent_tas();
    int nr;
    int wins;
    do_op(3, 3'd1, 6'd12, 32'd0, '0, 1'b0, '0, 1'b1, "R12 lock setup");
    run_group(4'b1111, 3'd2, 6'd12, '0, nr);
    check_rotation(4'b1111, nr);
    wins = 0;
    for (int k = 0; k < nr; k++) if (g_ok[k]) wins++;
    chk(wins == 1, "R12 single lock winner", 64'(wins), 1);
    chk(g_ok[0] == 1'b1 && g_old[0] == '0, "R12 first holder", 64'(g_old[0]), 0);
    for (int k = 1; k < nr; k++)
      chk(g_old[k] == 32'd1, "R12 losers see held", 64'(g_old[k]), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_write();
    t_tas();
    t_xchg();
    t_cas();
    t_finc();
    t_reserved();
    t_concurrent_inc();
    t_concurrent_tas();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule